// File: doc/BRIEF.md
# Vectored Interrupt Acceptance and Priority Unit

This unit sits beside one processor core and decides which pending interrupt vector the core should take next. It keeps three 256-entry bit vectors: pending requests, vectors currently being serviced, and the trigger kind (level or edge) of each request. It also keeps a software task priority and a configuration word that holds the spurious vector and the software enable bit. A vector number doubles as its priority, and its upper four bits form its priority class.

Requests arrive as a vector number plus a level/edge flag. The core takes an interrupt with a one-cycle acknowledge strobe and reads the returned vector in that same cycle. It ends service with an end-of-interrupt strobe or with a register write. A small word-indexed register port lets software set the task priority and the configuration word, and read back every piece of state. The unit drives an interrupt-pending line and the current processor priority.

Top module: `irq_acceptor`

## Requirements
- R1: The highest-numbered set bit wins everywhere: an acknowledge takes the highest pending vector, and end of interrupt releases the highest in-service vector.
- R2: The processor priority `ppr_o` equals the task priority when the task priority's bits 7:4 are at least the class (bits 7:4) of the highest in-service vector, and that class shifted left by 4 otherwise. An empty in-service set counts as class 0.
- R3: `irq_pending_o` is high only when configuration bit 8 (enable) is set and a request is pending. When the processor priority is nonzero, the highest request's class must also be strictly greater than the processor priority's class.
- R4: A request sets its pending bit. It sets its trigger bit when `req_level_i` is 1 and clears that bit when `req_level_i` is 0.
- R5: An accepted acknowledge clears the highest pending bit, sets that vector's in-service bit and returns the vector on `ack_vector_o` in the acknowledge cycle.
- R6: When the task priority is nonzero and the highest pending vector is at or below it, an acknowledge still clears that pending bit. It returns the configuration word's bits 7:0 and leaves the in-service set unchanged.
- R7: An acknowledge while the unit is disabled, or while no request is pending, returns configuration bits 7:0 and changes neither the pending nor the in-service set.
- R8: End of interrupt is raised by `eoi_i` or by a write to index 0x0B. It clears the highest in-service bit and has no effect when the in-service set is empty.
- R9: After reset the task priority is 0 and the configuration word is 0x0FF, so the unit starts disabled. A configuration write keeps bits 8:0 only.
- R10: Reads by word index: 0x08 task priority, 0x0A processor priority, 0x0F configuration word, 0x28 error status. In-service words are at 0x10 to 0x17, trigger words at 0x18 to 0x1F and pending words at 0x20 to 0x27. Word k holds vectors 32k to 32k+31, with vector 32k in bit 0.
- R11: Writes to the processor priority index, the error status index and all in-service, trigger and pending word indexes leave the state unchanged.
- R12: A read or write at any other index sets error status bit 7, which then stays set until reset. Such a read returns 0.
- R13: A request and an acknowledge in the same cycle both take effect, even for the same vector. An end of interrupt and an acknowledge in the same cycle both take effect: the release acts on the in-service set as it stood before the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_vector_i | input | 8 | Requested vector number |
| req_level_i | input | 1 | 1 marks the request as level triggered, 0 as edge triggered |
| ack_i | input | 1 | Core acknowledge strobe |
| ack_vector_o | output | 8 | Vector handed to the core; valid while ack_i is high |
| eoi_i | input | 1 | End-of-interrupt strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_idx_i | input | 8 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_idx_i |
| irq_pending_o | output | 1 | Interrupt pending toward the core |
| ppr_o | output | 8 | Current processor priority |

## Verification
The checker watches several rules on every cycle. The pending line never rises while the unit is disabled or has no request. The processor priority never drops below the task priority. A request always lands in the pending set, and new in-service bits appear only on an acknowledge. An empty in-service set stays empty without one, a disabled acknowledge disturbs nothing, and the error flag is sticky. The directed scenarios cover what needs a history to judge: the exact vector returned when the task priority blocks a request, the class-boundary cases of the pending rule, the trigger bit following the latest request kind, and the word layout of the register reads. They also cover same-cycle request/acknowledge and acknowledge/release collisions.

// File: rtl/irq_acc_pkg.sv
package irq_acc_pkg;
  localparam int unsigned VEC_W = 8;
  localparam int unsigned WORD_W = 32;

  localparam logic [7:0] IDX_TPR  = 8'h08;
  localparam logic [7:0] IDX_PPR  = 8'h0A;
  localparam logic [7:0] IDX_EOI  = 8'h0B;
  localparam logic [7:0] IDX_CFG  = 8'h0F;
  localparam logic [7:0] IDX_ISR  = 8'h10;
  localparam logic [7:0] IDX_TMR  = 8'h18;
  localparam logic [7:0] IDX_IRR  = 8'h20;
  localparam logic [7:0] IDX_ESR  = 8'h28;

  typedef struct packed {
    logic [8:0] cfg;   // [8] enable, [7:0] spurious vector
    logic [7:0] tpr;
    logic       esr_ill;
  } ctrl_t;

  // indexes a write may target without raising an error
  function automatic logic wr_known(logic [7:0] idx, int unsigned words);
    logic [7:0] top;
    top = 8'(IDX_IRR + 8'(words));
    return (idx == IDX_TPR) || (idx == IDX_PPR) || (idx == IDX_EOI) ||
           (idx == IDX_CFG) || (idx == IDX_ESR) ||
           ((idx >= IDX_ISR) && (idx < top));
  endfunction
endpackage

// File: rtl/irq_hp_find.sv
module irq_hp_find #(
  parameter int unsigned W = 256,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_reg_read.sv
module irq_reg_read
  import irq_acc_pkg::*;
#(
  parameter int unsigned NUM_VEC = 256,
  localparam int unsigned NUM_WORDS = NUM_VEC / WORD_W
) (
  input  logic [7:0]         idx_i,
  input  ctrl_t              ctrl_i,
  input  logic [7:0]         ppr_i,
  input  logic [NUM_VEC-1:0] isr_i,
  input  logic [NUM_VEC-1:0] tmr_i,
  input  logic [NUM_VEC-1:0] irr_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic               hit_o
);
  always_comb begin
    rdata_o = '0;
    hit_o   = 1'b1;
    unique case (idx_i)
      IDX_TPR: rdata_o = {24'b0, ctrl_i.tpr};
      IDX_PPR: rdata_o = {24'b0, ppr_i};
      IDX_CFG: rdata_o = {23'b0, ctrl_i.cfg};
      IDX_ESR: rdata_o = {24'b0, ctrl_i.esr_ill, 7'b0};
      default: hit_o = 1'b0;
    endcase
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (idx_i == 8'(IDX_ISR + 8'(k))) begin
        rdata_o = isr_i[k*WORD_W +: WORD_W];
        hit_o   = 1'b1;
      end
      if (idx_i == 8'(IDX_TMR + 8'(k))) begin
        rdata_o = tmr_i[k*WORD_W +: WORD_W];
        hit_o   = 1'b1;
      end
      if (idx_i == 8'(IDX_IRR + 8'(k))) begin
        rdata_o = irr_i[k*WORD_W +: WORD_W];
        hit_o   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_acceptor.sv
module irq_acceptor
  import irq_acc_pkg::*;
#(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned DATA_W  = WORD_W,
  localparam int unsigned VW        = $clog2(NUM_VEC),
  localparam int unsigned NUM_WORDS = NUM_VEC / WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VW-1:0]     req_vector_i,
  input  logic              req_level_i,
  input  logic              ack_i,
  output logic [VW-1:0]     ack_vector_o,
  input  logic              eoi_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [7:0]        reg_idx_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_pending_o,
  output logic [7:0]        ppr_o
);
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
  ctrl_t ctrl_q, ctrl_d;

  logic [VW-1:0] irr_hi, isr_hi;
  logic          irr_any, isr_any;

  irq_hp_find #(.W(NUM_VEC)) u_irr_find (.vec_i(irr_q), .idx_o(irr_hi), .any_o(irr_any));
  irq_hp_find #(.W(NUM_VEC)) u_isr_find (.vec_i(isr_q), .idx_o(isr_hi), .any_o(isr_any));

  // priority
  logic [3:0] isr_cls;
  logic       enable;
  assign isr_cls = isr_any ? isr_hi[VW-1:VW-4] : 4'd0;
  assign enable  = ctrl_q.cfg[8];
  assign ppr_o   = (ctrl_q.tpr[7:4] >= isr_cls) ? ctrl_q.tpr : {isr_cls, 4'd0};
  assign irq_pending_o = enable && irr_any &&
                         ((ppr_o == 8'd0) || (irr_hi[VW-1:VW-4] > ppr_o[7:4]));

  // acknowledge
  logic ack_take, ack_blocked, eoi_do;
  assign ack_take     = ack_i && enable && irr_any;
  assign ack_blocked  = (ctrl_q.tpr != 8'd0) && (irr_hi <= ctrl_q.tpr);
  assign ack_vector_o = (ack_take && !ack_blocked) ? irr_hi : ctrl_q.cfg[7:0];
  assign eoi_do       = eoi_i || (reg_we_i && (reg_idx_i == IDX_EOI));

  // register port
  logic [WORD_W-1:0] rd_word;
  logic              rd_hit;
  logic              unused_wdata;

  irq_reg_read #(.NUM_VEC(NUM_VEC)) u_read (
    .idx_i(reg_idx_i), .ctrl_i(ctrl_q), .ppr_i(ppr_o),
    .isr_i(isr_q), .tmr_i(tmr_q), .irr_i(irr_q),
    .rdata_o(rd_word), .hit_o(rd_hit)
  );

  assign reg_rdata_o  = rd_hit ? DATA_W'(rd_word) : '0;
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:9];

  always_comb begin
    irr_d  = irr_q;
    isr_d  = isr_q;
    tmr_d  = tmr_q;
    ctrl_d = ctrl_q;
    // clear before set so same-cycle collisions keep both effects
    if (ack_take) irr_d[irr_hi] = 1'b0;
    if (req_valid_i) begin
      irr_d[req_vector_i] = 1'b1;
      tmr_d[req_vector_i] = req_level_i;
    end
    if (eoi_do && isr_any) isr_d[isr_hi] = 1'b0;
    if (ack_take && !ack_blocked) isr_d[irr_hi] = 1'b1;
    if (reg_we_i && (reg_idx_i == IDX_TPR)) ctrl_d.tpr = reg_wdata_i[7:0];
    if (reg_we_i && (reg_idx_i == IDX_CFG)) ctrl_d.cfg = reg_wdata_i[8:0];
    if ((reg_we_i && !wr_known(reg_idx_i, NUM_WORDS)) || (reg_re_i && !rd_hit))
      ctrl_d.esr_ill = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      isr_q  <= '0;
      tmr_q  <= '0;
      ctrl_q <= '{cfg: 9'h0FF, tpr: 8'h00, esr_ill: 1'b0};
    end else begin
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      tmr_q  <= tmr_d;
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/irq_acceptor_chk.sv
module irq_acceptor_chk #(
  parameter int unsigned NUM_VEC = 256,
  localparam int unsigned VW = $clog2(NUM_VEC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [VW-1:0]      req_vector_i,
  input logic               ack_i,
  input logic               irq_pending_o,
  input logic [7:0]         ppr_o,
  input logic [7:0]         tpr_q,
  input logic [8:0]         cfg_q,
  input logic               esr_q,
  input logic [NUM_VEC-1:0] irr_q,
  input logic [NUM_VEC-1:0] isr_q
);
  p_pending_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pending_o |-> (cfg_q[8] && (irr_q != '0)));

  p_ppr_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o >= tpr_q);

  p_req_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> irr_q[$past(req_vector_i)]);

  p_isr_set_by_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> ((isr_q & ~$past(isr_q)) == '0));

  p_eoi_empty_noop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((isr_q == '0) && !ack_i) |=> (isr_q == '0));

  p_ack_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !cfg_q[8] && !req_valid_i) |=> ($stable(irr_q) && $stable(isr_q)));

  p_esr_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esr_q |=> esr_q);
endmodule

bind irq_acceptor irq_acceptor_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_vector_i(req_vector_i), .ack_i(ack_i), .irq_pending_o(irq_pending_o),
  .ppr_o(ppr_o), .tpr_q(ctrl_q.tpr), .cfg_q(ctrl_q.cfg), .esr_q(ctrl_q.esr_ill),
  .irr_q(irr_q), .isr_q(isr_q)
);

// File: tb/tb_irq_acceptor.sv
module tb_irq_acceptor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [7:0]  req_vector_i = '0;
  logic        req_level_i = 1'b0;
  logic        ack_i = 1'b0;
  logic [7:0]  ack_vector_o;
  logic        eoi_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_re_i = 1'b0;
  logic [7:0]  reg_idx_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_pending_o;
  logic [7:0]  ppr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_acceptor dut (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(bit rq, logic [7:0] v, bit lvl, bit ack, bit eoi, output logic [7:0] av);
    @(negedge clk_i);
    req_valid_i = rq; req_vector_i = v; req_level_i = lvl; ack_i = ack; eoi_i = eoi;
    #1 av = ack_vector_o;
    @(posedge clk_i);
    #1 req_valid_i = 1'b0; ack_i = 1'b0; eoi_i = 1'b0;
  endtask

  task automatic req(logic [7:0] v, bit lvl);
    logic [7:0] av;
    cyc(1'b1, v, lvl, 1'b0, 1'b0, av);
  endtask

  task automatic ack_chk(string r, logic [7:0] exp);
    logic [7:0] av;
    cyc(1'b0, 8'h0, 1'b0, 1'b1, 1'b0, av);
    chk(r, {24'b0, av}, {24'b0, exp});
  endtask

  task automatic eoi();
    logic [7:0] av;
    cyc(1'b0, 8'h0, 1'b0, 1'b0, 1'b1, av);
  endtask

  task automatic wr(logic [7:0] idx, logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_idx_i = idx; reg_wdata_i = d;
    @(posedge clk_i);
    #1 reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(string r, logic [7:0] idx, logic [31:0] exp);
    logic [31:0] v;
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_idx_i = idx;
    #1 v = reg_rdata_o;
    @(posedge clk_i);
    #1 reg_re_i = 1'b0;
    chk(r, v, exp);
  endtask

  task automatic pend_chk(string r, bit exp);
    @(negedge clk_i);
    #1 chk(r, {31'b0, irq_pending_o}, {31'b0, exp});
  endtask

  task automatic t_reset();
    rd_chk("R9 cfg reset", 8'h0F, 32'h0FF);
    rd_chk("R9 tpr reset", 8'h08, 32'h0);
    rd_chk("R2 ppr reset", 8'h0A, 32'h0);
    pend_chk("R3 idle pending", 1'b0);
  endtask

  task automatic t_disabled();
    req(8'h45, 1'b0);
    rd_chk("R4 irr word2", 8'h22, 32'h20);
    pend_chk("R3 disabled no pending", 1'b0);
    ack_chk("R7 disabled ack vector", 8'hFF);
    rd_chk("R7 irr kept", 8'h22, 32'h20);
    rd_chk("R7 isr empty", 8'h12, 32'h0);
  endtask

  task automatic t_enable();
    wr(8'h0F, 32'hFFFF_F3A5);
    rd_chk("R9 cfg 9 bits", 8'h0F, 32'h1A5);
    pend_chk("R3 enabled pending", 1'b1);
  endtask

  task automatic t_trigger();
    req(8'h80, 1'b1);
    req(8'h30, 1'b1);
    rd_chk("R4 tmr level 0x30", 8'h19, 32'h0001_0000);
    req(8'h30, 1'b0);
    rd_chk("R4 tmr edge clears", 8'h19, 32'h0);
    rd_chk("R4 tmr level 0x80", 8'h1C, 32'h1);
    rd_chk("R4 tmr edge 0x45", 8'h1A, 32'h0);
    rd_chk("R10 irr word1", 8'h21, 32'h0001_0000);
  endtask

  task automatic t_ack_eoi();
    ack_chk("R1 highest vector", 8'h80);
    rd_chk("R5 irr cleared", 8'h24, 32'h0);
    rd_chk("R5 isr set", 8'h14, 32'h1);
    rd_chk("R2 ppr from isr", 8'h0A, 32'h80);
    pend_chk("R3 lower class masked", 1'b0);
    eoi();
    rd_chk("R8 eoi clears", 8'h14, 32'h0);
    pend_chk("R3 unmasked after eoi", 1'b1);
    ack_chk("R5 ack 0x45", 8'h45);
    ack_chk("R5 ack 0x30", 8'h30);
    rd_chk("R2 ppr nested", 8'h0A, 32'h40);
    wr(8'h0B, 32'h0);
    rd_chk("R8 write eoi highest", 8'h12, 32'h0);
    rd_chk("R1 lower stays", 8'h11, 32'h0001_0000);
    rd_chk("R2 ppr after eoi", 8'h0A, 32'h30);
    eoi();
    eoi();
    rd_chk("R8 empty eoi", 8'h11, 32'h0);
    rd_chk("R2 ppr empty", 8'h0A, 32'h0);
    pend_chk("R3 nothing pending", 1'b0);
  endtask

  task automatic t_tpr();
    wr(8'h08, 32'h57);
    rd_chk("R10 tpr read", 8'h08, 32'h57);
    rd_chk("R2 ppr from tpr", 8'h0A, 32'h57);
    req(8'h55, 1'b0);
    pend_chk("R3 class equal masked", 1'b0);
    ack_chk("R6 spurious returned", 8'hA5);
    rd_chk("R6 irr cleared", 8'h22, 32'h0);
    rd_chk("R6 isr unchanged", 8'h12, 32'h0);
    req(8'h58, 1'b0);
    pend_chk("R3 same class above tpr", 1'b0);
    ack_chk("R6 above tpr accepted", 8'h58);
    rd_chk("R5 isr 0x58", 8'h12, 32'h0100_0000);
    rd_chk("R2 tpr dominates same class", 8'h0A, 32'h57);
    eoi();
    req(8'h70, 1'b0);
    pend_chk("R3 higher class", 1'b1);
    ack_chk("R5 ack 0x70", 8'h70);
    rd_chk("R2 isr class wins", 8'h0A, 32'h70);
    eoi();
    wr(8'h08, 32'h0);
  endtask

  task automatic t_ignored();
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h0A, 32'hFFFF_FFFF);
    wr(8'h28, 32'hFFFF_FFFF);
    rd_chk("R11 irr write ignored", 8'h20, 32'h0);
    rd_chk("R11 isr write ignored", 8'h10, 32'h0);
    rd_chk("R11 tmr write ignored", 8'h18, 32'h0);
    rd_chk("R11 ppr write ignored", 8'h0A, 32'h0);
    rd_chk("R11 esr clean", 8'h28, 32'h0);
  endtask

  task automatic t_undefined();
    rd_chk("R12 undefined read zero", 8'h09, 32'h0);
    rd_chk("R12 esr bit7", 8'h28, 32'h80);
    wr(8'h3F, 32'hFFFF_FFFF);
    rd_chk("R12 esr stays", 8'h28, 32'h80);
  endtask

  task automatic t_collide();
    logic [7:0] av;
    req(8'h90, 1'b0);
    cyc(1'b1, 8'h90, 1'b0, 1'b1, 1'b0, av);
    chk("R13 req+ack vector", {24'b0, av}, 32'h90);
    rd_chk("R13 irr kept by req", 8'h24, 32'h0001_0000);
    rd_chk("R13 isr set by ack", 8'h14, 32'h0001_0000);
    cyc(1'b0, 8'h0, 1'b0, 1'b1, 1'b1, av);
    chk("R13 ack+eoi vector", {24'b0, av}, 32'h90);
    rd_chk("R13 isr after ack+eoi", 8'h14, 32'h0001_0000);
    rd_chk("R13 irr after ack+eoi", 8'h24, 32'h0);
    eoi();
    cyc(1'b1, 8'hA0, 1'b1, 1'b1, 1'b0, av);
    chk("R7 empty ack spurious", {24'b0, av}, 32'hA5);
    rd_chk("R13 req lands on empty ack", 8'h25, 32'h1);
    rd_chk("R7 isr untouched", 8'h14, 32'h0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_disabled();
    t_enable();
    t_trigger();
    t_ack_eoi();
    t_tpr();
    t_ignored();
    t_undefined();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule